// File: doc/BRIEF.md
# Shared Serial Pin Router with Sample-Clock Divider

This block decides which of two independent serial engines drives a shared transmit/receive pin pair. One engine is a generic clocked serial unit, the other a UART. A small control register holds the mode choice, a sample-clock enable, a sample-clock direction and a divisor. An external pin-reassignment input can move the UART onto an alternate transmit/receive pin pair, numbered 14 and 15. While that input is high, the primary pair always belongs to the clocked serial unit, whatever the mode bit holds.

The block also makes a programmable sample clock for a bidirectional general-purpose pin, numbered 16. The block clock `clk_i` runs at twice the 3.6864 MHz reference rate. The divided output toggles once every (divisor + 1) block cycles, so its frequency is the reference divided by (divisor + 1). A 12-bit divisor therefore covers the range from the full reference frequency down to 900 Hz. Software writes the whole register through a single write port and can always read it back.

Top module: `serpin_router`

## Requirements
- R1: With the pin-reassignment input low, a mode bit of 0 connects the primary transmit pin and its enable to the clocked serial unit and sends the primary receive pin to it, while the UART receive output idles at 1. A mode bit of 1 drives the primary transmit pin from the UART with the enable at 1 and sends the primary receive pin to the UART, while the clocked-serial receive output idles at 1.
- R2: While the UART holds the primary pins (mode 1, reassignment low), the enable and direction fields are ignored: the pin-16 enable and output stay at 0. The stored field values remain unchanged in the read-back.
- R3: Reset clears only the mode bit, to 0, and holds the pin-16 output at 0. The enable, direction and divisor fields keep the values they had before reset.
- R4: With the pin-reassignment input high, the mode bit is ignored and the primary pins behave as in mode 0. The alternate transmit pin carries the UART transmit with its enable at 1, and the UART receive output follows the alternate receive pin. With the input low, the alternate transmit pin and its enable are 0.
- R5: An enable field of 0 keeps the pin-16 enable and output at 0.
- R6: With the enable field at 1, a direction of 0 keeps the pin-16 enable at 0 (pin treated as an unused input). A direction of 1 raises the pin-16 enable and drives the divided clock.
- R7: While driven, the pin-16 output stays high for exactly divisor+1 block cycles and low for divisor+1 block cycles. This holds for divisors 0 and 4095.
- R8: A divisor written while the clock runs does not cut short the half-period in progress. The new value governs the half-periods that begin after the next toggle.
- R9: A write while the stored mode bit is 1 updates only the mode bit. The enable, direction and divisor fields change only on writes made while the stored mode bit is 0.
- R10: Read-back places the mode bit at bit 0, the enable field at bit 1, the direction field at bit 2 and the divisor at bits 15:4. Bit 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, twice the reference rate |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read-back |
| pin_reassign_i | input | 1 | Moves the UART to the alternate pins |
| csu_tx_i | input | 1 | Clocked serial unit transmit data |
| csu_tx_oe_i | input | 1 | Clocked serial unit transmit enable |
| csu_rx_o | output | 1 | Receive data to the clocked serial unit |
| uart_tx_i | input | 1 | UART transmit data |
| uart_rx_o | output | 1 | Receive data to the UART |
| pri_tx_o | output | 1 | Primary transmit pin data |
| pri_tx_oe_o | output | 1 | Primary transmit pin enable |
| pri_rx_i | input | 1 | Primary receive pin |
| alt_tx_o | output | 1 | Alternate transmit pin (14) data |
| alt_tx_oe_o | output | 1 | Alternate transmit pin (14) enable |
| alt_rx_i | input | 1 | Alternate receive pin (15) |
| smp_clk_o | output | 1 | Pin-16 sample clock data |
| smp_clk_oe_o | output | 1 | Pin-16 output enable |

## Verification
The bench builds the block with its default parameters: a 12-bit divisor placed at bit 4 of a 16-bit register. At the block rate, the largest divisor gives a half-period of 4096 cycles, so the bench measures the 900 Hz end of the range directly, alongside divisor 0 and mid-range values. The same default width puts the full read-back layout, bit 3 and the top divisor bit included, under direct check.

// File: rtl/serpin_pkg.sv
package serpin_pkg;

    // Read-back / write bit positions of the control register
    localparam int MODE_BIT = 0;
    localparam int CEN_BIT  = 1;
    localparam int CDIR_BIT = 2;
    localparam int DIV_LSB  = 4;

    // Idle level presented to a receiver that does not own the pins
    localparam logic RX_IDLE = 1'b1;

    typedef struct packed {
        logic uart_mode;   // 1: UART owns the primary pins
        logic clk_en;      // sample-clock function on
        logic clk_dir;     // 1: drive the divided clock out
    } serpin_flags_t;

endpackage

// File: rtl/serpin_ctrl_reg.sv
module serpin_ctrl_reg
    import serpin_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output serpin_flags_t     flags_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        serpin_flags_t    flags;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  unused_wr;

    assign unused_wr = ^wr_data_i;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en_i) begin
            ctrl_d.flags.uart_mode = wr_data_i[MODE_BIT];
            // other fields accept a write only while the clocked mode is stored
            if (!ctrl_q.flags.uart_mode) begin
                ctrl_d.flags.clk_en  = wr_data_i[CEN_BIT];
                ctrl_d.flags.clk_dir = wr_data_i[CDIR_BIT];
                ctrl_d.div           = wr_data_i[DIV_LSB +: DIV_W];
            end
        end
    end

    // only the mode bit has a reset value; the rest hold through reset
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q.flags.uart_mode <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        rd_data_o                     = '0;
        rd_data_o[MODE_BIT]           = ctrl_q.flags.uart_mode;
        rd_data_o[CEN_BIT]            = ctrl_q.flags.clk_en;
        rd_data_o[CDIR_BIT]           = ctrl_q.flags.clk_dir;
        rd_data_o[DIV_LSB +: DIV_W]   = ctrl_q.div;
    end

    assign flags_o = ctrl_q.flags;
    assign div_o   = ctrl_q.div;

    // R9: fields locked while UART mode is stored
    p_fields_locked_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && ctrl_q.flags.uart_mode) |=>
            ($stable(div_o) && $stable(flags_o.clk_en) && $stable(flags_o.clk_dir)));

    // R9: without a write nothing moves
    p_hold_no_write_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/serpin_pin_mux.sv
module serpin_pin_mux
    import serpin_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic uart_mode_i,
    input  logic reassign_i,
    input  logic csu_tx_i,
    input  logic csu_tx_oe_i,
    input  logic uart_tx_i,
    input  logic pri_rx_i,
    input  logic alt_rx_i,
    output logic pri_tx_o,
    output logic pri_tx_oe_o,
    output logic alt_tx_o,
    output logic alt_tx_oe_o,
    output logic csu_rx_o,
    output logic uart_rx_o,
    output logic clk_mode_o
);

    logic uart_on_pri;

    always_comb begin
        uart_on_pri = uart_mode_i && !reassign_i;
        clk_mode_o  = !uart_on_pri;

        // primary pair
        if (uart_on_pri) begin
            pri_tx_o    = uart_tx_i;
            pri_tx_oe_o = 1'b1;
            csu_rx_o    = RX_IDLE;
        end else begin
            pri_tx_o    = csu_tx_i;
            pri_tx_oe_o = csu_tx_oe_i;
            csu_rx_o    = pri_rx_i;
        end

        // alternate pair and UART receive source
        if (reassign_i) begin
            alt_tx_o    = uart_tx_i;
            alt_tx_oe_o = 1'b1;
            uart_rx_o   = alt_rx_i;
        end else begin
            alt_tx_o    = 1'b0;
            alt_tx_oe_o = 1'b0;
            uart_rx_o   = uart_on_pri ? pri_rx_i : RX_IDLE;
        end
    end

    // R1: UART on the primary pins
    p_uart_primary_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (uart_mode_i && !reassign_i) |->
            (pri_tx_oe_o && pri_tx_o == uart_tx_i && uart_rx_o == pri_rx_i && csu_rx_o));

    // R4: reassignment forces clocked serial on the primary pins
    p_reassign_primary_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        reassign_i |->
            (pri_tx_o == csu_tx_i && csu_rx_o == pri_rx_i && uart_rx_o == alt_rx_i));

    // R4: alternate pin quiet without reassignment
    p_alt_quiet_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !reassign_i |-> (!alt_tx_oe_o && !alt_tx_o));

endmodule

// File: rtl/serpin_clk_div.sv
module serpin_clk_div #(
    parameter int DIV_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             active_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             clk_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_i) begin
            st_d.cnt = div_i;
            st_d.lvl = 1'b0;
        end else if (st_q.cnt == '0) begin
            // terminal count: toggle and pick up the current divisor
            st_d.cnt = div_i;
            st_d.lvl = !st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = st_q.lvl;

    // R5: output low once stopped
    p_low_when_idle_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !active_i |=> !clk_o);

    // R8: output never moves before the terminal count
    p_hold_mid_count_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (active_i && st_q.cnt != '0) |=> $stable(clk_o));

    // R7: the terminal count always produces an edge
    p_edge_at_tc_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (active_i && st_q.cnt == '0) |=> (clk_o != $past(clk_o)));

endmodule

// File: rtl/serpin_router.sv
module serpin_router
    import serpin_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              pin_reassign_i,
    input  logic              csu_tx_i,
    input  logic              csu_tx_oe_i,
    output logic              csu_rx_o,
    input  logic              uart_tx_i,
    output logic              uart_rx_o,
    output logic              pri_tx_o,
    output logic              pri_tx_oe_o,
    input  logic              pri_rx_i,
    output logic              alt_tx_o,
    output logic              alt_tx_oe_o,
    input  logic              alt_rx_i,
    output logic              smp_clk_o,
    output logic              smp_clk_oe_o
);

    serpin_flags_t    flags;
    logic [DIV_W-1:0] div;
    logic             clk_mode;
    logic             clk_active;

    serpin_ctrl_reg #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_reg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .flags_o   (flags),
        .div_o     (div),
        .rd_data_o (rd_data_o)
    );

    serpin_pin_mux u_mux (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .uart_mode_i (flags.uart_mode),
        .reassign_i  (pin_reassign_i),
        .csu_tx_i    (csu_tx_i),
        .csu_tx_oe_i (csu_tx_oe_i),
        .uart_tx_i   (uart_tx_i),
        .pri_rx_i    (pri_rx_i),
        .alt_rx_i    (alt_rx_i),
        .pri_tx_o    (pri_tx_o),
        .pri_tx_oe_o (pri_tx_oe_o),
        .alt_tx_o    (alt_tx_o),
        .alt_tx_oe_o (alt_tx_oe_o),
        .csu_rx_o    (csu_rx_o),
        .uart_rx_o   (uart_rx_o),
        .clk_mode_o  (clk_mode)
    );

    // clock runs only in effective clocked-serial mode with enable and drive direction
    assign clk_active = clk_mode && flags.clk_en && flags.clk_dir;

    serpin_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .active_i (clk_active),
        .div_i    (div),
        .clk_o    (smp_clk_o)
    );

    assign smp_clk_oe_o = clk_active;

    // R6: pin 16 is driven only with both enable and direction set
    p_oe_needs_fields_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_clk_oe_o |-> (flags.clk_en && flags.clk_dir));

    // R2: UART mode on the primary pins silences pin 16
    p_uart_no_clock_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (flags.uart_mode && !pin_reassign_i) |=> !smp_clk_o);

endmodule

// File: tb/serpin_router_tb.sv
module serpin_router_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        reassign, csu_tx, csu_tx_oe, uart_tx, pri_rx, alt_rx;
    logic        csu_rx, uart_rx, pri_tx, pri_tx_oe, alt_tx, alt_tx_oe;
    logic        smp_clk, smp_clk_oe;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 250 MHz

    serpin_router dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .pin_reassign_i(reassign),
        .csu_tx_i(csu_tx), .csu_tx_oe_i(csu_tx_oe), .csu_rx_o(csu_rx),
        .uart_tx_i(uart_tx), .uart_rx_o(uart_rx),
        .pri_tx_o(pri_tx), .pri_tx_oe_o(pri_tx_oe), .pri_rx_i(pri_rx),
        .alt_tx_o(alt_tx), .alt_tx_oe_o(alt_tx_oe), .alt_rx_i(alt_rx),
        .smp_clk_o(smp_clk), .smp_clk_oe_o(smp_clk_oe)
    );

    function automatic logic [15:0] enc(bit m, bit en, bit dir, int dv);
        logic [11:0] d12 = dv[11:0];
        return {d12, 1'b0, dir, en, m};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_rise();
        int g = 0;
        while (smp_clk !== 1'b0 && g < 20000) begin @(negedge clk); g++; end
        while (smp_clk !== 1'b1 && g < 20000) begin @(negedge clk); g++; end
    endtask

    task automatic count_lvl(logic lvl, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (smp_clk === lvl && n < 20000);
    endtask

    task automatic meas(output int hi, output int lo);
        wait_rise();
        count_lvl(1'b1, hi);
        count_lvl(1'b0, lo);
    endtask

    task automatic t_reset_state();
        chk("R3 reset mode bit", 32'(rd_data[0]), 0);
        chk("R3 reset pin16 out", 32'(smp_clk), 0);
    endtask

    task automatic t_pins();
        wr(enc(0, 0, 0, 0));
        reassign = 0; csu_tx = 1; csu_tx_oe = 0; uart_tx = 0; pri_rx = 0; alt_rx = 1;
        @(negedge clk);
        chk("R1 clocked tx", {pri_tx, pri_tx_oe}, 2'b10);
        chk("R1 clocked rx", {csu_rx, uart_rx}, 2'b01);
        csu_tx = 0; csu_tx_oe = 1; pri_rx = 1;
        @(negedge clk);
        chk("R1 clocked tx2", {pri_tx, pri_tx_oe, csu_rx}, 3'b011);
        wr(enc(1, 0, 0, 0));
        uart_tx = 1; pri_rx = 0;
        @(negedge clk);
        chk("R1 uart tx", {pri_tx, pri_tx_oe}, 2'b11);
        chk("R1 uart rx", {uart_rx, csu_rx}, 2'b01);
        chk("R4 alt quiet", {alt_tx, alt_tx_oe}, 2'b00);
    endtask

    task automatic t_reassign();
        // mode 1 still stored
        reassign = 1; csu_tx = 1; csu_tx_oe = 1; uart_tx = 0; pri_rx = 0; alt_rx = 0;
        @(negedge clk);
        chk("R4 primary to clocked", {pri_tx, pri_tx_oe, csu_rx}, 3'b110);
        chk("R4 alt tx", {alt_tx, alt_tx_oe}, 2'b01);
        chk("R4 uart rx alt", 32'(uart_rx), 0);
        uart_tx = 1; alt_rx = 1; pri_rx = 1;
        @(negedge clk);
        chk("R4 alt follow", {alt_tx, uart_rx, csu_rx}, 3'b111);
        reassign = 0;
        wr(enc(0, 0, 0, 0));
    endtask

    task automatic t_enable();
        int hi, lo;
        wr(enc(0, 0, 1, 3));
        repeat (20) @(negedge clk);
        chk("R5 disabled", {smp_clk, smp_clk_oe}, 2'b00);
        wr(enc(0, 1, 0, 3));
        repeat (20) @(negedge clk);
        chk("R6 input dir", {smp_clk, smp_clk_oe}, 2'b00);
        wr(enc(0, 1, 1, 3));
        chk("R6 output dir oe", 32'(smp_clk_oe), 1);
        meas(hi, lo);
        chk("R6 driven clock hi", 32'(hi), 4);
    endtask

    task automatic t_period(int dv);
        int hi, lo;
        wr(enc(0, 1, 1, dv));
        meas(hi, lo);   // first full period after the change
        meas(hi, lo);
        chk($sformatf("R7 high div=%0d", dv), 32'(hi), 32'(dv + 1));
        chk($sformatf("R7 low div=%0d", dv), 32'(lo), 32'(dv + 1));
    endtask

    task automatic t_change();
        int hi, lo;
        wr(enc(0, 1, 1, 9));
        wait_rise();
        wr_en = 1'b1; wr_data = enc(0, 1, 1, 2);
        hi = 0;
        do begin
            @(negedge clk); wr_en = 1'b0; hi++;
        end while (smp_clk === 1'b1 && hi < 20000);
        chk("R8 old half-period kept", 32'(hi), 10);
        count_lvl(1'b0, lo);
        chk("R8 new half-period", 32'(lo), 3);
        meas(hi, lo);
        chk("R8 new period", {16'(hi), 16'(lo)}, {16'd3, 16'd3});
    endtask

    task automatic t_uart_ignores();
        wr(enc(0, 1, 1, 5));
        wr(enc(1, 1, 1, 5));
        repeat (30) @(negedge clk);
        chk("R2 no clock in uart mode", {smp_clk, smp_clk_oe}, 2'b00);
        chk("R2 fields kept", 32'(rd_data), 32'(enc(1, 1, 1, 5)));
        reassign = 1;
        @(negedge clk);
        chk("R4 mode ignored, clock oe", 32'(smp_clk_oe), 1);
        reassign = 0;
        wr(enc(1, 0, 0, 12));
        chk("R9 locked write", 32'(rd_data), 32'(enc(1, 1, 1, 5)));
        wr(enc(0, 0, 0, 12));
        chk("R9 clear only mode", 32'(rd_data), 32'(enc(0, 1, 1, 5)));
        wr(enc(0, 0, 0, 12));
        chk("R9 unlocked write", 32'(rd_data), 32'(enc(0, 0, 0, 12)));
    endtask

    task automatic t_readback();
        wr(16'hA5C6);
        chk("R10 layout bit3 zero", 32'(rd_data), 32'h0000A5C6);
        wr(16'hFFFF);
        chk("R10 layout full", 32'(rd_data), 32'h0000FFF7);
        wr(16'h0000);
    endtask

    task automatic t_reset_retain();
        wr(enc(0, 1, 0, 77));
        wr(enc(1, 1, 0, 77));
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        chk("R3 out low in reset", 32'(smp_clk), 0);
        rst = 0;
        @(negedge clk);
        chk("R3 fields retained", 32'(rd_data), 32'(enc(0, 1, 0, 77)));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; wr_data = '0;
        reassign = 0; csu_tx = 0; csu_tx_oe = 0; uart_tx = 0; pri_rx = 0; alt_rx = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_state();
        t_pins();
        t_reassign();
        t_enable();
        t_period(0);
        t_period(1);
        t_period(200);
        t_period(4095);
        t_change();
        t_uart_ignores();
        t_readback();
        t_reset_retain();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule